// File: doc/BRIEF.md
# Skip-Condition Instruction Sequencer

This block sits in the execute stage of a small 8-bit controller. It decides whether a conditional-skip instruction is taken, and then suppresses the instructions that follow it. Each cycle it receives one instruction slot: a valid flag, a decoded instruction class, the file-register operand and a 3-bit bit index. In the same cycle it returns the write-back value for the counting skips, plus a squash flag that tells the rest of the pipeline to discard the current slot.

When a skip is taken, the squash window does not close after one slot. It stays open across any run of page-select or bank-select slots that arrive directly behind the skip, and it closes only after the first ordinary instruction has also been discarded. Every discarded slot still costs one cycle. The block keeps a free-running cycle count and the cycle cost of the most recent skip operation, so the extra cycles can be seen at the ports. The block also holds the page and bank selection registers, so that discarded selects can be shown to have no effect.

Top module: `skipseq_top`

## Requirements
- R1: Class 1 (decrement-and-skip) drives wb_data = operand-1 with wb_en high in the same cycle, and its skip is taken when that result is 0x00.
- R2: Class 2 (increment-and-skip) drives wb_data = operand+1 with wb_en high in the same cycle, and its skip is taken when that result is 0x00.
- R3: Class 3 (bit test, skip if clear) takes its skip when operand[bit_idx] is 0. It never raises wb_en.
- R4: Class 4 (bit test, skip if set) takes its skip when operand[bit_idx] is 1. It never raises wb_en.
- R5: After a taken skip, the next valid slot has squash high in its own cycle.
- R6: While a squash window is open, valid slots of class 5 (page select) or class 6 (bank select) are squashed and keep the window open. The first valid slot of any other class is squashed and closes the window, so the slot after it is not squashed.
- R7: op_cycles becomes 1 in the cycle after a skip is evaluated. It then grows by one after each squashed slot, so a taken skip followed by one select and one ordinary slot reads 3. A skip that is not taken reads 1 and squashes nothing.
- R8: A squashed slot has wb_en low and skip_taken low, and it leaves page_sel and bank_sel unchanged.
- R9: A skip-class slot that is squashed is not evaluated, so the slot after it is not squashed because of it.
- R10: cycle_count rises by one after every valid slot, squashed or not. Cycles with valid low change neither cycle_count nor an open squash window, and squash is low in them.
- R11: An unsquashed class 5 slot loads operand[2:0] into page_sel, and an unsquashed class 6 slot loads operand[2:0] into bank_sel. The new value is visible from the next cycle.
- R12: After reset, squash is low, and cycle_count, op_cycles, page_sel and bank_sel are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid_i | input | 1 | An instruction occupies this cycle |
| instr_class_i | input | 3 | 0 other, 1 dec-skip, 2 inc-skip, 3 test-clear, 4 test-set, 5 page, 6 bank (7 is treated as other) |
| operand_i | input | 8 | File-register operand (select value for page/bank) |
| bit_idx_i | input | 3 | Bit position tested by classes 3 and 4 |
| wb_data_o | output | 8 | Write-back value for classes 1 and 2 |
| wb_en_o | output | 1 | Write-back strobe, low when squashed |
| skip_taken_o | output | 1 | The current slot is a skip whose condition holds |
| squash_o | output | 1 | Discard the current slot |
| cycle_count_o | output | 16 | Cycles consumed by valid slots |
| op_cycles_o | output | 16 | Cycle cost of the most recent skip operation |
| page_sel_o | output | 3 | Current page selection |
| bank_sel_o | output | 3 | Current bank selection |

## Verification
The write-back value, the write strobe, skip_taken and squash are combinational on the current slot and the registered window state. The bench therefore drives each slot at the falling edge and compares these four results a quarter period later, in the same cycle. The window, page_sel, bank_sel, cycle_count and op_cycles change at the rising edge that closes a slot. Their checks are made in the following cycle, after that edge and before the next slot is applied. The table walk carries state from one row to the next, so the expected squash flags follow directly from the window rules.

// File: rtl/skipseq_pkg.sv
// Package: shared instruction-class encoding for the skip sequencer.
// Assumes the decoder delivers a 3-bit class code; code 7 means "ordinary".
package skipseq_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER  = 3'd0,
        CLS_DECSKP = 3'd1,
        CLS_INCSKP = 3'd2,
        CLS_TSTCLR = 3'd3,
        CLS_TSTSET = 3'd4,
        CLS_PAGE   = 3'd5,
        CLS_BANK   = 3'd6,
        CLS_RSVD   = 3'd7
    } instr_cls_e;

endpackage

// File: rtl/skipseq_cond.sv
// Module: skipseq_cond
// Combinational classifier. It computes the write-back value for the
// counting skips and whether the current slot's skip condition holds.
// Assumes nothing about validity or squashing: the callers gate its outputs.
module skipseq_cond
    import skipseq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  instr_cls_e          cls_i,
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [IDX_W-1:0]    bit_idx_i,
    output logic [DATA_W-1:0]   wb_data_o,
    output logic                wb_write_o,
    output logic                is_skip_o,
    output logic                cond_o,
    output logic                is_sel_o
);

    logic [DATA_W-1:0] dec_val;
    logic [DATA_W-1:0] inc_val;
    logic              tested_bit;

    // Purpose: arithmetic results of the two counting skips.
    always_comb begin
        dec_val = operand_i - DATA_W'(1);
        inc_val = operand_i + DATA_W'(1);
    end

    // Purpose: select the tested bit of the operand.
    always_comb begin
        tested_bit = operand_i[bit_idx_i];
    end

    // Purpose: decode class into write-back, skip condition and select flag.
    always_comb begin
        wb_data_o  = '0;
        wb_write_o = 1'b0;
        is_skip_o  = 1'b0;
        cond_o     = 1'b0;
        is_sel_o   = 1'b0;
        unique case (cls_i)
            CLS_DECSKP: begin
                wb_data_o  = dec_val;
                wb_write_o = 1'b1;
                is_skip_o  = 1'b1;
                cond_o     = (dec_val == '0);
            end
            CLS_INCSKP: begin
                wb_data_o  = inc_val;
                wb_write_o = 1'b1;
                is_skip_o  = 1'b1;
                cond_o     = (inc_val == '0);
            end
            CLS_TSTCLR: begin
                is_skip_o = 1'b1;
                cond_o    = ~tested_bit;
            end
            CLS_TSTSET: begin
                is_skip_o = 1'b1;
                cond_o    = tested_bit;
            end
            CLS_PAGE, CLS_BANK: begin
                is_sel_o = 1'b1;
            end
            default: begin
                is_sel_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/skipseq_window.sv
// Module: skipseq_window
// Holds the squash window. A taken skip opens it. Page/bank slots keep
// it open, and the first other valid slot is discarded and closes it.
// Assumes one slot per cycle when valid_i is high.
module skipseq_window (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic is_skip_i,
    input  logic cond_i,
    input  logic is_sel_i,
    output logic squash_o,
    output logic eval_o,
    output logic taken_o
);

    logic open_q;
    logic open_d;

    // Purpose: per-slot squash, evaluation and taken flags.
    always_comb begin
        squash_o = valid_i & open_q;
        eval_o   = valid_i & ~open_q & is_skip_i;
        taken_o  = eval_o & cond_i;
    end

    // Purpose: next state of the window.
    always_comb begin
        open_d = open_q;
        if (valid_i) begin
            open_d = open_q ? is_sel_i : taken_o;
        end
    end

    // Purpose: window register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    // R5: a taken skip must squash the next valid slot.
    p_open_after_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_skip_i && cond_i && !squash_o) |=> open_q);

    // R6: an ordinary slot inside the window closes it.
    p_close_on_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o && !is_sel_i) |=> !open_q);

    // R9: a squashed skip is never evaluated.
    p_no_cascade_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o && is_skip_i) |-> !taken_o);

    // R10: idle cycles leave the window alone.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i) |=> $stable(open_q));

endmodule

// File: rtl/skipseq_cycles.sv
// Module: skipseq_cycles
// Counts the cycles used by valid slots, and the cost of the latest skip
// operation (the skip itself plus every slot it squashed).
// Assumes CNT_W is wide enough that wrap-around is acceptable.
module skipseq_cycles #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             eval_i,
    input  logic             squash_i,
    output logic [CNT_W-1:0] cycle_count_o,
    output logic [CNT_W-1:0] op_cycles_o
);

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] op_q;

    // Purpose: free-running count of consumed slot cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       total_q <= '0;
        else if (valid_i) total_q <= total_q + CNT_W'(1);
    end

    // Purpose: cost of the current or most recent skip operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        op_q <= '0;
        else if (eval_i)   op_q <= CNT_W'(1);
        else if (squash_i) op_q <= op_q + CNT_W'(1);
    end

    assign cycle_count_o = total_q;
    assign op_cycles_o   = op_q;

    // R10: idle cycles do not consume cycles.
    p_idle_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i) |=> $stable(total_q));

    // R7: an evaluated skip starts its cost at one cycle.
    p_op_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> (op_q == CNT_W'(1)));

endmodule

// File: rtl/skipseq_selregs.sv
// Module: skipseq_selregs
// Page and bank selection registers. They are written only by select
// slots that are not squashed. Assumes the select value is in the low
// operand bits.
module skipseq_selregs #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             squash_i,
    input  logic             is_page_i,
    input  logic             is_bank_i,
    input  logic [SEL_W-1:0] value_i,
    output logic [SEL_W-1:0] page_o,
    output logic [SEL_W-1:0] bank_o
);

    logic [SEL_W-1:0] page_q;
    logic [SEL_W-1:0] bank_q;
    logic             commit;

    // Purpose: a slot commits state only if valid and not squashed.
    always_comb commit = valid_i & ~squash_i;

    // Purpose: page selection register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   page_q <= '0;
        else if (commit && is_page_i) page_q <= value_i;
    end

    // Purpose: bank selection register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bank_q <= '0;
        else if (commit && is_bank_i) bank_q <= value_i;
    end

    assign page_o = page_q;
    assign bank_o = bank_q;

    // R8: squashed slots leave both selections untouched.
    p_squash_keeps_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> ($stable(page_q) && $stable(bank_q)));

endmodule

// File: rtl/skipseq_top.sv
// Module: skipseq_top
// Skip-condition sequencer for one execute slot per cycle. It evaluates
// skips and opens a squash window that absorbs a run of page/bank selects
// plus one ordinary slot. It also reports write-back and cycle costs.
// Assumes the class code is already decoded and that fetch follows squash_o.
module skipseq_top
    import skipseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid_i,
    input  logic [2:0]        instr_class_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic [DATA_W-1:0] wb_data_o,
    output logic              wb_en_o,
    output logic              skip_taken_o,
    output logic              squash_o,
    output logic [CNT_W-1:0]  cycle_count_o,
    output logic [CNT_W-1:0]  op_cycles_o,
    output logic [SEL_W-1:0]  page_sel_o,
    output logic [SEL_W-1:0]  bank_sel_o
);

    instr_cls_e cls;
    logic       wb_write;
    logic       is_skip;
    logic       cond;
    logic       is_sel;
    logic       squash;
    logic       eval;
    logic       taken;
    logic       is_page;
    logic       is_bank;

    // Purpose: interpret the raw class code.
    always_comb begin
        cls     = instr_cls_e'(instr_class_i);
        is_page = (cls == CLS_PAGE);
        is_bank = (cls == CLS_BANK);
    end

    skipseq_cond #(.DATA_W(DATA_W)) u_cond (
        .cls_i      (cls),
        .operand_i  (operand_i),
        .bit_idx_i  (bit_idx_i),
        .wb_data_o  (wb_data_o),
        .wb_write_o (wb_write),
        .is_skip_o  (is_skip),
        .cond_o     (cond),
        .is_sel_o   (is_sel)
    );

    skipseq_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (slot_valid_i),
        .is_skip_i (is_skip),
        .cond_i    (cond),
        .is_sel_i  (is_sel),
        .squash_o  (squash),
        .eval_o    (eval),
        .taken_o   (taken)
    );

    skipseq_cycles #(.CNT_W(CNT_W)) u_cycles (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (slot_valid_i),
        .eval_i        (eval),
        .squash_i      (squash),
        .cycle_count_o (cycle_count_o),
        .op_cycles_o   (op_cycles_o)
    );

    skipseq_selregs #(.SEL_W(SEL_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (slot_valid_i),
        .squash_i  (squash),
        .is_page_i (is_page),
        .is_bank_i (is_bank),
        .value_i   (operand_i[SEL_W-1:0]),
        .page_o    (page_sel_o),
        .bank_o    (bank_sel_o)
    );

    // Purpose: gate write-back and export flags.
    always_comb begin
        wb_en_o      = wb_write & slot_valid_i & ~squash;
        skip_taken_o = taken;
        squash_o     = squash;
    end

    // R8: a squashed slot never writes back.
    p_squash_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (!wb_en_o && !skip_taken_o));

    // R12: the first cycle after reset has no open window.
    p_reset_clear_r12: assert property (@(posedge clk)
        (!rst_n) |=> !squash_o);

endmodule

// File: tb/skipseq_tb.sv
module skipseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic [7:0]  opnd = 8'h00;
    logic [2:0]  idx = 3'd0;
    logic [7:0]  wb_data;
    logic        wb_en;
    logic        taken;
    logic        squash;
    logic [15:0] cyc;
    logic [15:0] opc;
    logic [2:0]  page;
    logic [2:0]  bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    skipseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .slot_valid_i(vld), .instr_class_i(cls),
        .operand_i(opnd), .bit_idx_i(idx), .wb_data_o(wb_data), .wb_en_o(wb_en),
        .skip_taken_o(taken), .squash_o(squash), .cycle_count_o(cyc),
        .op_cycles_o(opc), .page_sel_o(page), .bank_sel_o(bank)
    );

    // row: valid, class, operand, idx, exp squash, exp wb_en, exp wb, exp taken
    localparam int NV = 23;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 3'd1, 8'h05, 3'd0, 1'b0, 1'b1, 8'h04, 1'b0}, // R1 no skip
        {1'b1, 3'd1, 8'h01, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1}, // R1 taken
        {1'b1, 3'd5, 8'h03, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 page squashed
        {1'b1, 3'd0, 8'hAA, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 plain squashed
        {1'b1, 3'd0, 8'h11, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}, // R6 window closed
        {1'b1, 3'd2, 8'hFF, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1}, // R2 taken
        {1'b1, 3'd6, 8'h02, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 bank
        {1'b1, 3'd5, 8'h05, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 page
        {1'b1, 3'd6, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 bank
        {1'b1, 3'd2, 8'hFF, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R9 squashed skip
        {1'b1, 3'd0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}, // R9 no cascade
        {1'b1, 3'd2, 8'h7F, 3'd0, 1'b0, 1'b1, 8'h80, 1'b0}, // R2 no skip
        {1'b1, 3'd3, 8'hF7, 3'd3, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 taken
        {1'b1, 3'd0, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R5
        {1'b1, 3'd4, 8'h08, 3'd3, 1'b0, 1'b0, 8'h00, 1'b1}, // R4 taken
        {1'b1, 3'd2, 8'hFF, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R9 squashed inc
        {1'b1, 3'd0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}, // R9
        {1'b1, 3'd4, 8'hF7, 3'd3, 1'b0, 1'b0, 8'h00, 1'b0}, // R4 not taken
        {1'b1, 3'd3, 8'h80, 3'd7, 1'b0, 1'b0, 8'h00, 1'b0}, // R3 not taken
        {1'b1, 3'd4, 8'h80, 3'd7, 1'b0, 1'b0, 8'h00, 1'b1}, // R4 bit 7
        {1'b1, 3'd3, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0}, // R9 squashed test
        {1'b1, 3'd5, 8'h06, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}, // R11 page load
        {1'b1, 3'd0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}  // plain
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one slot at the falling edge; sample a quarter period later
    task automatic slot(input logic v, input logic [2:0] c, input logic [7:0] o, input logic [2:0] b);
        @(negedge clk);
        vld = v; cls = c; opnd = o; idx = b;
        #5;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        slot(1'b1, 3'd0, 8'h00, 3'd0);
        // R12 reset state
        chk("R12 squash", {15'd0, squash}, 16'd0);
        chk("R12 cycle_count", cyc, 16'd0);
        chk("R12 op_cycles", opc, 16'd0);
        chk("R12 page", {13'd0, page}, 16'd0);
        chk("R12 bank", {13'd0, bank}, 16'd0);
        vld = 1'b0;
        // reset cycle count starts after the idle slot: re-reset for clean count
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        for (int i = 0; i < NV; i++) begin
            logic [25:0] r;
            r = VEC[i];
            slot(r[25], r[24:22], r[21:14], r[13:11]);
            chk($sformatf("R5/R6 squash row %0d", i), {15'd0, squash}, {15'd0, r[10]});
            chk($sformatf("R8 wb_en row %0d", i), {15'd0, wb_en}, {15'd0, r[9]});
            if (r[9]) chk($sformatf("R1/R2 wb_data row %0d", i), {8'd0, wb_data}, {8'd0, r[8:1]});
            chk($sformatf("R3/R4 taken row %0d", i), {15'd0, taken}, {15'd0, r[0]});
        end
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R11 page after table", {13'd0, page}, 16'd6);
        chk("R8 bank untouched by squashed selects", {13'd0, bank}, 16'd0);
        chk("R10 cycle_count after table", cyc, 16'd23);
        chk("R7 op_cycles taken skip one squash", opc, 16'd2);

        // R7 three-cycle operation: skip, page, ordinary
        slot(1'b1, 3'd1, 8'h01, 3'd0);
        slot(1'b1, 3'd5, 8'h02, 3'd0);
        slot(1'b1, 3'd0, 8'h00, 3'd0);
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R7 op_cycles three", opc, 16'd3);
        chk("R8 page held", {13'd0, page}, 16'd6);

        // R7 not-taken costs one
        slot(1'b1, 3'd4, 8'h00, 3'd2);
        slot(1'b1, 3'd0, 8'h00, 3'd0);
        chk("R7 not taken squashes nothing", {15'd0, squash}, 16'd0);
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R7 op_cycles one", opc, 16'd1);

        // R10 idle cycles inside an open window
        slot(1'b1, 3'd3, 8'h00, 3'd5);
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R10 squash low when idle", {15'd0, squash}, 16'd0);
        chk("R10 count after skip", cyc, 16'd29);
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R10 idle no count", cyc, 16'd29);
        slot(1'b1, 3'd0, 8'h00, 3'd0);
        chk("R10 window held across idle", {15'd0, squash}, 16'd1);

        // R11 unsquashed bank load
        slot(1'b1, 3'd6, 8'hFB, 3'd0);
        chk("R11 bank select not squashed", {15'd0, squash}, 16'd0);
        slot(1'b0, 3'd0, 8'h00, 3'd0);
        chk("R11 bank loaded", {13'd0, bank}, 16'd3);
        chk("R10 final count", cyc, 16'd31);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule